// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Access Sequencer

This block lets synchronous logic read and write an external asynchronous static RAM of 256K sixteen-bit words. A host presents one request at a time: a valid strobe, a write flag, an 18-bit word address, sixteen bits of write data, a two-bit lane mask and a wait-state count. The sequencer turns each request into a timed pin sequence on the memory. It drives the active-low chip select, output strobe, write strobe and two lane selects, the address bus, and a split data bus with separate out, out-enable and in signals. When the access finishes it returns a single-cycle done pulse and, for reads, the captured word.

Every access runs through the same phases. A setup cycle presents the address and lane selects with both strobes inactive. An access phase holds the strobe for the programmed number of cycles. A hold cycle releases the strobe but keeps the address. A done cycle closes the access. Between accesses the memory is left deselected so that it drops into standby. A write that directly follows a read gets one extra idle cycle, so that the memory has let go of the data bus before the sequencer drives it. The wait-state count is chosen by the integrator so that the access phase covers the memory's access time at the system clock period.

Top module: `sram_ctl`

## Requirements
- R1: Out of reset and whenever idle, `req_ready` is high, chip select, both lane selects, output strobe and write strobe are high (inactive), and `mem_dq_oe` is low.
- R2: A write with a nonzero mask drives the write strobe low for exactly N cycles, with chip select low and the output strobe high. N is the wait count, and a count of 0 acts as 1. `done` rises N+2 clock edges after the accepting edge, and chip select is low for N+2 cycles.
- R3: Mask bit 0 enables the low lane (data bits 7:0, lane select bit 0 of `mem_lane_n`), and mask bit 1 enables the high lane (bits 15:8, lane select bit 1). During a write only the enabled lanes are stored. The other lane keeps its previous contents.
- R4: A read with a nonzero mask drives the output strobe low for exactly N cycles with the write strobe high. It samples `mem_dq_in` in the last of those cycles and presents the word on `rdata` while `done` is high. `done` rises N+2 edges after the accepting edge.
- R5: In read data, a lane whose mask bit is 0 reads as zero. A read with an all-zero mask returns zero.
- R6: `mem_dq_oe` is high only while the output strobe is high or the write strobe is low. The output and write strobes are never low together.
- R7: `mem_addr` equals the request address whenever chip select is low, and it stays stable for as long as chip select stays low.
- R8: A write accepted when the previous memory access was a read spends one extra cycle with all pins inactive before setup, so `done` rises N+3 edges after acceptance. `mem_dq_oe` only rises after a cycle with the output strobe high.
- R9: A request with an all-zero mask raises `done` on the cycle right after the accepting edge. Chip select stays high and no strobe goes low for that request.
- R10: `done` lasts exactly one cycle. `req_ready` is low from the accepting edge until after `done`, and a new request is taken only while `req_ready` is high.
- R11: A synchronous reset during an access returns all memory pins to the idle levels of R1 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 low byte, bit 1 high byte |
| wait_cycles | input | 4 | Strobe length in cycles (0 acts as 1), latched with the request |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result, valid with `done` after a read |
| mem_addr | output | 18 | Memory address bus |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_lane_n | output | 2 | Lane selects, active low, bit 0 low byte |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for `mem_dq_out` onto the shared bus |
| mem_dq_in | input | 16 | Data read from the shared bus |

## Verification
The assertions check, on every cycle, the bus rules that must never break: the idle pin levels, that the sequencer drives the data bus only while the memory is not driving it, that the two strobes are never low together, that the address is stable under chip select, that a write strobe comes with a lane select, and that done is a single-cycle pulse. Some behaviour can only be shown by scenarios against a behavioural memory model in the bench: access latency and strobe length for different wait counts, what each lane mask stores and returns, the extra turnaround cycle before a write that follows a read, the immediate completion of an empty mask, and recovery from a reset in the middle of an access.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
// Package: shared state encoding for the SRAM access sequencer.
// Assumes: one access in flight at a time; the state order is not decoded elsewhere.
package sram_ctl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_SETUP,
        ST_ACCESS,
        ST_HOLD,
        ST_DONE
    } sram_st_e;
endpackage

// File: rtl/sram_ctl_fsm.sv
`timescale 1ns/1ps
// Module: phase sequencer. Takes a request and steps through the phases
// turnaround, setup, strobe, hold and done, counting wait states.
// Assumes: the caller latches the request fields on `accept`.
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              mask_any,
    input  logic [WAIT_W-1:0] wait_cycles,
    output sram_st_e          state,
    output logic              accept,
    output logic              last_access
);
    logic [WAIT_W-1:0] ws_q;
    logic [WAIT_W-1:0] cnt_q;
    logic              prev_read_q;

    assign accept      = (state == ST_IDLE) && req_valid;
    assign last_access = (state == ST_ACCESS) && (cnt_q == '0);

    // Phase register, wait-state counter and last-access-direction flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            ws_q        <= '0;
            cnt_q       <= '0;
            prev_read_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    ws_q <= wait_cycles;
                    if (!mask_any) begin
                        state <= ST_DONE;
                    end else begin
                        prev_read_q <= !req_write;
                        state <= (req_write && prev_read_q) ? ST_TURN : ST_SETUP;
                    end
                end
                ST_TURN:  state <= ST_SETUP;
                ST_SETUP: begin
                    cnt_q <= (ws_q == '0) ? '0 : ws_q - 1'b1;
                    state <= ST_ACCESS;
                end
                ST_ACCESS: begin
                    if (cnt_q == '0) state <= ST_HOLD;
                    else             cnt_q <= cnt_q - 1'b1;
                end
                ST_HOLD:  state <= ST_DONE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assert_turn_then_setup_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TURN) |=> (state == ST_SETUP));
    assert_done_returns_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> (state == ST_IDLE));
endmodule

// File: rtl/sram_ctl_capture.sv
`timescale 1ns/1ps
// Module: read-data capture, one register slice per byte lane.
// Assumes: `cap` is high only in the last strobe cycle of a read; `clr`
// marks an empty-mask read, which returns zero.
module sram_ctl_capture #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cap,
    input  logic                    clr,
    input  logic [LANES-1:0]        lane_en,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic [LANES*LANE_W-1:0] rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Lane slice: sample the bus for enabled lanes, zero otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                rdata[g*LANE_W +: LANE_W] <= '0;
            end else if (cap) begin
                rdata[g*LANE_W +: LANE_W] <= lane_en[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
            end
        end
    end
endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
// Module: top of the asynchronous SRAM access sequencer. Latches the request,
// decodes the memory pins from the phase, and drives the split data bus.
// Assumes: the wait count covers the memory access time at the clock period.
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int LANE_W = 8,
    parameter int LANES  = 2,
    parameter int WAIT_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [LANES*LANE_W-1:0] req_wdata,
    input  logic [LANES-1:0]        req_mask,
    input  logic [WAIT_W-1:0]       wait_cycles,
    output logic                    req_ready,
    output logic                    done,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic                    mem_ce_n,
    output logic                    mem_oe_n,
    output logic                    mem_we_n,
    output logic [LANES-1:0]        mem_lane_n,
    output logic [LANES*LANE_W-1:0] mem_dq_out,
    output logic                    mem_dq_oe,
    input  logic [LANES*LANE_W-1:0] mem_dq_in
);
    localparam int DATA_W = LANES * LANE_W;

    sram_st_e              state;
    logic                  accept;
    logic                  last_access;
    logic                  wr_q;
    logic [ADDR_W-1:0]     addr_q;
    logic [DATA_W-1:0]     wdata_q;
    logic [LANES-1:0]      mask_q;
    logic                  active;
    logic                  strobe;

    sram_ctl_fsm #(.WAIT_W(WAIT_W)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .mask_any    (|req_mask),
        .wait_cycles (wait_cycles),
        .state       (state),
        .accept      (accept),
        .last_access (last_access)
    );

    // Request latch: hold address, data, mask and direction for the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else if (accept) begin
            wr_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            mask_q  <= req_mask;
        end
    end

    sram_ctl_capture #(.LANES(LANES), .LANE_W(LANE_W)) cap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (last_access && !wr_q),
        .clr     (accept && !req_write && (req_mask == '0)),
        .lane_en (mask_q),
        .dq_in   (mem_dq_in),
        .rdata   (rdata)
    );

    // Pin decode: select during setup/strobe/hold, strobe only in the access phase.
    always_comb begin
        active     = (state == ST_SETUP) || (state == ST_ACCESS) || (state == ST_HOLD);
        strobe     = (state == ST_ACCESS);
        mem_ce_n   = !active;
        mem_lane_n = ~(mask_q & {LANES{active}});
        mem_oe_n   = !(strobe && !wr_q);
        mem_we_n   = !(strobe && wr_q);
        mem_dq_oe  = active && wr_q;
        mem_dq_out = wdata_q;
        mem_addr   = addr_q;
        req_ready  = (state == ST_IDLE);
        done       = (state == ST_DONE);
    end

    assert_idle_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && (&mem_lane_n) && mem_oe_n && mem_we_n && !mem_dq_oe));
    assert_we_has_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && !(&mem_lane_n)));
    assert_bus_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n || !mem_we_n));
    assert_no_dual_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));
    assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
    assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> $past(mem_oe_n));
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/sram_ctl_tb.sv
`timescale 1ns/1ps
// Bench: table-driven accesses against a small behavioural SRAM model,
// then directed reset checks.
module sram_ctl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic [3:0]  wait_cycles = '0;
    logic        req_ready, done;
    logic [15:0] rdata;
    logic [17:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n;
    logic [1:0]  mem_lane_n;
    logic [15:0] mem_dq_out;
    logic        mem_dq_oe;
    logic [15:0] mem_dq_in;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sram_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .wait_cycles(wait_cycles), .req_ready(req_ready), .done(done), .rdata(rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_lane_n(mem_lane_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Behavioural memory: 64 words indexed by the low address bits.
    logic [15:0] mdl [64];
    always @(posedge clk) begin
        if (!rst_n && !finished && checks == 0) begin
            for (int i = 0; i < 64; i++) mdl[i] <= '0;
        end else if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
            if (!mem_lane_n[0]) mdl[mem_addr[5:0]][7:0]  <= mem_dq_out[7:0];
            if (!mem_lane_n[1]) mdl[mem_addr[5:0]][15:8] <= mem_dq_out[15:8];
        end
    end
    // Read path: an unselected lane shows filler so zeroing is visible.
    always_comb begin
        mem_dq_in = 16'hA5A5;
        if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
            if (!mem_lane_n[0]) mem_dq_in[7:0]  = mdl[mem_addr[5:0]][7:0];
            if (!mem_lane_n[1]) mem_dq_in[15:8] = mdl[mem_addr[5:0]][15:8];
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic        wr;
        logic [17:0] addr;
        logic [15:0] wdata;
        logic [1:0]  mask;
        logic [3:0]  ws;
        logic [15:0] exp;  // read data, or stored word after a write
        logic [3:0]  lat;  // edges from acceptance to done
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{1'b1, 18'h00003, 16'h1234, 2'b11, 4'd2, 16'h1234, 4'd4},
        '{1'b0, 18'h00003, 16'h0000, 2'b11, 4'd2, 16'h1234, 4'd4},
        '{1'b1, 18'h00003, 16'hABCD, 2'b01, 4'd1, 16'h12CD, 4'd4},
        '{1'b0, 18'h00003, 16'h0000, 2'b11, 4'd3, 16'h12CD, 4'd5},
        '{1'b1, 18'h00005, 16'h5678, 2'b10, 4'd0, 16'h5600, 4'd4},
        '{1'b0, 18'h00005, 16'h0000, 2'b10, 4'd1, 16'h5600, 4'd3},
        '{1'b0, 18'h00003, 16'h0000, 2'b01, 4'd1, 16'h00CD, 4'd3},
        '{1'b0, 18'h00003, 16'h0000, 2'b10, 4'd1, 16'h1200, 4'd3},
        '{1'b1, 18'h3FFFF, 16'h9ABC, 2'b11, 4'd1, 16'h9ABC, 4'd4},
        '{1'b0, 18'h3FFFF, 16'h0000, 2'b11, 4'd4, 16'h9ABC, 4'd6},
        '{1'b1, 18'h00007, 16'hFFFF, 2'b00, 4'd2, 16'h0000, 4'd0},
        '{1'b0, 18'h00007, 16'h0000, 2'b00, 4'd2, 16'h0000, 4'd0}
    };

    // One access: present request, then sample every cycle until done.
    task automatic run_req(input vec_t v);
        int lat = 0, n_we = 0, n_oe = 0, n_ce = 0, n_rdy = 0, n_badaddr = 0;
        int strobe_exp = (v.mask == 2'b00) ? 0 : ((v.ws == 0) ? 1 : int'(v.ws));
        @(negedge clk);
        chk(req_ready, "R10 ready before request", req_ready, 1);
        req_valid = 1'b1; req_write = v.wr; req_addr = v.addr;
        req_wdata = v.wdata; req_mask = v.mask; wait_cycles = v.ws;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && lat < 40) begin
            if (!mem_we_n) n_we++;
            if (!mem_oe_n) n_oe++;
            if (!mem_ce_n) n_ce++;
            if (req_ready) n_rdy++;
            if (!mem_ce_n && mem_addr != v.addr) n_badaddr++;
            @(negedge clk);
            lat++;
        end
        chk(lat == int'(v.lat), v.wr ? "R2/R8 write latency" : "R4 read latency", lat, v.lat);
        chk(n_we == (v.wr ? strobe_exp : 0), "R2 write strobe cycles", n_we, v.wr ? strobe_exp : 0);
        chk(n_oe == (v.wr ? 0 : strobe_exp), "R4 read strobe cycles", n_oe, v.wr ? 0 : strobe_exp);
        chk(n_ce == ((v.mask == 0) ? 0 : strobe_exp + 2), "R9 select cycles", n_ce,
            (v.mask == 0) ? 0 : strobe_exp + 2);
        chk(n_rdy == 0, "R10 ready low in access", n_rdy, 0);
        chk(n_badaddr == 0, "R7 address under select", n_badaddr, 0);
        if (v.wr) chk(mdl[v.addr[5:0]] == v.exp, "R3 stored word", mdl[v.addr[5:0]], v.exp);
        else      chk(rdata == v.exp, "R5 read data", rdata, v.exp);
        @(negedge clk);
        chk(!done, "R10 done single cycle", done, 0);
    endtask

    task automatic chk_idle(input string req);
        chk(req_ready && mem_ce_n && (&mem_lane_n) && mem_oe_n && mem_we_n && !mem_dq_oe,
            req, {mem_ce_n, mem_lane_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready}, 7'b1111101);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 idle after reset");
        chk(rdata == 16'h0 && !done, "R1 outputs after reset", {done, rdata}, 0);
        for (int i = 0; i < 12; i++) run_req(VECS[i]);
        // R11: reset in the middle of a long read strobe.
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 18'h3; req_mask = 2'b11;
        wait_cycles = 4'd8;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(!mem_oe_n, "R11 strobe active before reset", mem_oe_n, 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk_idle("R11 idle after mid-access reset");
        rst_n = 1'b1;
        // After reset no turnaround is owed: write latency is N+2.
        run_req('{1'b1, 18'h00009, 16'hC3C3, 2'b11, 4'd1, 16'hC3C3, 4'd3});
        chk_idle("R1 idle between requests");
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule